// File: doc/BRIEF.md
# ROM Pattern Fetch Unit

This unit executes the two-cycle table-lookup ("pattern") instruction of a small 4-bit microcontroller core. When the core signals a start, the unit builds a temporary ROM read address. It takes the current program counter as the base. The accumulator and the B register supply the low address field. The upper bits of B, the carry flag and a 3-bit operand are OR-merged into the page and bank fields. That address goes to a synchronous ROM port for one cycle, and the 10-bit word that comes back is then decoded.

Two command bits in the fetched word choose the destination of its eight data bits. The first destination is the accumulator/B pair. The second is the data I/O register pair R2/R3. A word may select one pair, both pairs, or neither. The program counter is never modified by the unit. It only receives the base value, and the one-cycle `done` pulse tells the core that the instruction has completed and the counter may advance. The accumulator and B register are held inside the unit. The core's ALU loads them through a write port that is honoured only while the unit is idle.

Top module: `pattern_fetch_unit`

## Requirements
- R1: During the fetch cycle, rom_addr[5:0] equals {acc, B[1:0]}, with acc and B taken in the cycle in which start was accepted.
- R2: During the fetch cycle, rom_addr[10:6] equals pc_in[10:6] ORed bitwise with {B[3:2], carry_in, op_p[1], op_p[0]}, all taken in the start cycle.
- R3: During the fetch cycle, rom_addr[11] equals pc_in[11] OR op_p[2]. The bank can therefore rise from 0 to 1 but never fall.
- R4: A start accepted at a clock edge makes rom_re high for exactly the next cycle. done is high for exactly the cycle after that. The two are never high together.
- R5: If bit 8 of the fetched word is 1, the edge that ends the done cycle loads acc with word[7:4] and B with word[3:0].
- R6: If bit 9 of the fetched word is 1, the same edge loads R2 with word[7:4] and R3 with word[3:0]. When bits 8 and 9 are both 1, both pairs load.
- R7: If bits 9:8 of the fetched word are both 0, none of acc, B, R2 or R3 changes.
- R8: While an instruction is in progress (fetch or done cycle), start and ab_we are ignored: no new fetch begins and acc/B are not loaded from ab_wdata.
- R9: After synchronous reset the unit is idle, rom_re and done are low, and acc, B, R2 and R3 are all zero.
- R10: In an idle cycle, ab_we loads acc with ab_wdata[7:4] and B with ab_wdata[3:0] at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a pattern instruction (accepted only when idle) |
| op_p | input | 3 | Instruction operand p |
| pc_in | input | 12 | Current program counter (base address) |
| carry_in | input | 1 | Carry flag |
| ab_we | input | 1 | ALU write strobe for acc/B |
| ab_wdata | input | 8 | ALU write data: [7:4] to acc, [3:0] to B |
| rom_addr | output | 12 | Referenced ROM address |
| rom_re | output | 1 | ROM read enable (fetch cycle) |
| rom_data | input | 10 | ROM word, valid the cycle after rom_re |
| done | output | 1 | Instruction complete; program counter may advance |
| acc_out | output | 4 | Accumulator |
| b_out | output | 4 | B register |
| r2_out | output | 4 | Data I/O register R2 |
| r3_out | output | 4 | Data I/O register R3 |

## Verification
A corrupted latched address shows on rom_addr in the fetch cycle, one cycle after start, and every field can be compared against operands the bench knows. A sequencer that stalls, repeats or restarts shows as a missing, doubled or early rom_re or done pulse within two cycles. A wrong write-enable decode, or a write leaking through while busy, shows on the four register outputs one edge after done. The sweep covers every accumulator, B, carry and operand combination over several program counter bases, which puts all four command-bit combinations through both banks.

// File: rtl/pfu_pkg.sv
package pfu_pkg;
    localparam int NIB_W  = 4;
    localparam int OP_W   = 3;
    localparam int OFFS_W = NIB_W + 2;
    localparam int PAGE_W = 5;
    localparam int ADDR_W = 1 + PAGE_W + OFFS_W;
    localparam int DATA_W = 2 * NIB_W;
    localparam int WORD_W = DATA_W + 2;
    localparam int NPAIR  = 2;
    localparam int PAIR_AB = 0;
    localparam int PAIR_IO = 1;

    typedef logic [NIB_W-1:0] nib_t;

    typedef struct packed {
        logic              bank;
        logic [PAGE_W-1:0] page;
        logic [OFFS_W-1:0] offs;
    } rom_addr_t;

    typedef struct packed {
        logic to_io;
        logic to_ab;
        nib_t hi;
        nib_t lo;
    } pat_word_t;

    typedef struct packed {
        nib_t hi;
        nib_t lo;
    } pair_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_EXEC  = 2'd2
    } pfu_state_t;

    function automatic rom_addr_t form_ref_addr(
        input rom_addr_t       pc,
        input nib_t            acc,
        input nib_t            b,
        input logic            carry,
        input logic [OP_W-1:0] p
    );
        rom_addr_t r;
        r.bank = pc.bank | p[OP_W-1];
        r.page = pc.page | {b[NIB_W-1:NIB_W-2], carry, p[1:0]};
        r.offs = {acc, b[1:0]};
        return r;
    endfunction
endpackage

// File: rtl/pfu_addr_former.sv
module pfu_addr_former
    import pfu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            capture,
    input  logic [ADDR_W-1:0] pc,
    input  nib_t            acc,
    input  nib_t            b,
    input  logic            carry,
    input  logic [OP_W-1:0] p,
    output rom_addr_t       addr_q
);
    rom_addr_t addr_d;

    always_comb begin
        addr_d = form_ref_addr(rom_addr_t'(pc), acc, b, carry, p);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (capture) begin
            addr_q <= addr_d;
        end
    end
endmodule

// File: rtl/pfu_seq.sv
module pfu_seq
    import pfu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic idle,
    output logic accept,
    output logic fetch,
    output logic exec
);
    pfu_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_FETCH;
            ST_FETCH: state_d = ST_EXEC;
            ST_EXEC:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign idle   = (state_q == ST_IDLE);
    assign accept = idle & start;
    assign fetch  = (state_q == ST_FETCH);
    assign exec   = (state_q == ST_EXEC);
endmodule

// File: rtl/pfu_pairs.sv
module pfu_pairs
    import pfu_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NPAIR-1:0]      we,
    input  pair_t [NPAIR-1:0]     wd,
    output pair_t [NPAIR-1:0]     q
);
    for (genvar i = 0; i < NPAIR; i++) begin : g_pair
        pair_t r_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                r_q <= '0;
            end else if (we[i]) begin
                r_q <= wd[i];
            end
        end
        assign q[i] = r_q;
    end
endmodule

// File: rtl/pattern_fetch_unit.sv
module pattern_fetch_unit
    import pfu_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [OP_W-1:0]     op_p,
    input  logic [ADDR_W-1:0]   pc_in,
    input  logic                carry_in,
    input  logic                ab_we,
    input  logic [DATA_W-1:0]   ab_wdata,
    output logic [ADDR_W-1:0]   rom_addr,
    output logic                rom_re,
    input  logic [WORD_W-1:0]   rom_data,
    output logic                done,
    output logic [NIB_W-1:0]    acc_out,
    output logic [NIB_W-1:0]    b_out,
    output logic [NIB_W-1:0]    r2_out,
    output logic [NIB_W-1:0]    r3_out
);
    logic              idle, accept, fetch, exec;
    rom_addr_t         addr_q;
    pat_word_t         word;
    logic [NPAIR-1:0]  pair_we;
    pair_t [NPAIR-1:0] pair_wd;
    pair_t [NPAIR-1:0] pair_q;

    pfu_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .idle   (idle),
        .accept (accept),
        .fetch  (fetch),
        .exec   (exec)
    );

    pfu_addr_former u_addr (
        .clk     (clk),
        .rst     (rst),
        .capture (accept),
        .pc      (pc_in),
        .acc     (pair_q[PAIR_AB].hi),
        .b       (pair_q[PAIR_AB].lo),
        .carry   (carry_in),
        .p       (op_p),
        .addr_q  (addr_q)
    );

    assign word = pat_word_t'(rom_data);

    always_comb begin
        pair_we[PAIR_AB] = (exec & word.to_ab) | (idle & ab_we);
        pair_we[PAIR_IO] = exec & word.to_io;
        if (exec) begin
            pair_wd[PAIR_AB].hi = word.hi;
            pair_wd[PAIR_AB].lo = word.lo;
        end else begin
            pair_wd[PAIR_AB] = pair_t'(ab_wdata);
        end
        pair_wd[PAIR_IO].hi = word.hi;
        pair_wd[PAIR_IO].lo = word.lo;
    end

    pfu_pairs u_pairs (
        .clk (clk),
        .rst (rst),
        .we  (pair_we),
        .wd  (pair_wd),
        .q   (pair_q)
    );

    assign rom_addr = addr_q;
    assign rom_re   = fetch;
    assign done     = exec;
    assign acc_out  = pair_q[PAIR_AB].hi;
    assign b_out    = pair_q[PAIR_AB].lo;
    assign r2_out   = pair_q[PAIR_IO].hi;
    assign r3_out   = pair_q[PAIR_IO].lo;
endmodule

// File: rtl/pfu_checker.sv
module pfu_checker
    import pfu_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [OP_W-1:0]     op_p,
    input logic [ADDR_W-1:0]   pc_in,
    input logic                carry_in,
    input logic [ADDR_W-1:0]   rom_addr,
    input logic                rom_re,
    input logic [WORD_W-1:0]   rom_data,
    input logic                done,
    input logic [NIB_W-1:0]    acc_out,
    input logic [NIB_W-1:0]    b_out,
    input logic [NIB_W-1:0]    r2_out,
    input logic [NIB_W-1:0]    r3_out
);
    AST_OFFS_FIELD: assert property (@(posedge clk) disable iff (rst)
        rom_re |-> rom_addr[OFFS_W-1:0] == {$past(acc_out), $past(b_out[1:0])}); // R1

    AST_PAGE_MERGE: assert property (@(posedge clk) disable iff (rst)
        rom_re |-> rom_addr[ADDR_W-2:OFFS_W] ==
            ($past(pc_in[ADDR_W-2:OFFS_W]) |
             {$past(b_out[NIB_W-1:NIB_W-2]), $past(carry_in), $past(op_p[1:0])})); // R2

    AST_BANK_UP: assert property (@(posedge clk) disable iff (rst)
        rom_re |-> rom_addr[ADDR_W-1] == ($past(pc_in[ADDR_W-1]) | $past(op_p[OP_W-1]))); // R3

    AST_RE_THEN_DONE: assert property (@(posedge clk) disable iff (rst)
        rom_re |=> (done && !rom_re)); // R4

    AST_DONE_AFTER_RE: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(rom_re)); // R4

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(rom_re && done)); // R4

    AST_AB_LOAD: assert property (@(posedge clk) disable iff (rst)
        (done && rom_data[DATA_W]) |=> {acc_out, b_out} == $past(rom_data[DATA_W-1:0])); // R5

    AST_IO_LOAD: assert property (@(posedge clk) disable iff (rst)
        (done && rom_data[DATA_W+1]) |=> {r2_out, r3_out} == $past(rom_data[DATA_W-1:0])); // R6

    AST_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (done && rom_data[DATA_W+1:DATA_W] == 2'b00) |=>
            ($stable(acc_out) && $stable(b_out) && $stable(r2_out) && $stable(r3_out))); // R7

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        done |=> !rom_re); // R8

    AST_IO_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |=> ($stable(r2_out) && $stable(r3_out))); // R6
endmodule

bind pattern_fetch_unit pfu_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_p     (op_p),
    .pc_in    (pc_in),
    .carry_in (carry_in),
    .rom_addr (rom_addr),
    .rom_re   (rom_re),
    .rom_data (rom_data),
    .done     (done),
    .acc_out  (acc_out),
    .b_out    (b_out),
    .r2_out   (r2_out),
    .r3_out   (r3_out)
);

// File: tb/pattern_fetch_unit_bench.sv
`timescale 1ns/1ps
module pattern_fetch_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  op_p = '0;
    logic [11:0] pc_in = '0;
    logic        carry_in = 1'b0;
    logic        ab_we = 1'b0;
    logic [7:0]  ab_wdata = '0;
    logic [11:0] rom_addr;
    logic        rom_re;
    logic [9:0]  rom_data = '0;
    logic        done;
    logic [3:0]  acc_out, b_out, r2_out, r3_out;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    pattern_fetch_unit u_pattern_fetch_unit (
        .clk(clk), .rst(rst), .start(start), .op_p(op_p), .pc_in(pc_in),
        .carry_in(carry_in), .ab_we(ab_we), .ab_wdata(ab_wdata),
        .rom_addr(rom_addr), .rom_re(rom_re), .rom_data(rom_data),
        .done(done), .acc_out(acc_out), .b_out(b_out),
        .r2_out(r2_out), .r3_out(r3_out)
    );

    function automatic logic [9:0] rom_fn(input logic [11:0] a);
        logic [7:0] lo8, hi8, mix;
        lo8 = a[7:0];
        hi8 = a[11:4];
        mix = hi8 + lo8 * 8'd13;
        return {a[1:0], mix};
    endfunction

    always_ff @(posedge clk) begin
        if (rom_re) rom_data <= rom_fn(rom_addr);
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R4 watchdog expired actual=hung expected=finished");
        finish_up();
    end

    logic [3:0] exp_r2 = '0;
    logic [3:0] exp_r3 = '0;

    task automatic run_one(input logic [11:0] pc, input logic [3:0] a,
                           input logic [3:0] b, input logic c, input logic [2:0] p);
        logic [11:0] ea;
        logic [9:0]  w;
        logic [3:0]  eacc, eb;
        // load acc/B in idle (R10)
        @(negedge clk);
        ab_we = 1'b1; ab_wdata = {a, b};
        @(negedge clk);
        ab_we = 1'b0;
        check({acc_out, b_out} == {a, b}, "R10 idle ab load", {acc_out, b_out}, {a, b});
        pc_in = pc; carry_in = c; op_p = p; start = 1'b1;
        @(negedge clk);
        // fetch cycle; keep start high and write junk to test R8
        ab_we = 1'b1; ab_wdata = ~{a, b};
        pc_in = ~pc; carry_in = ~c; op_p = ~p;
        ea[11]   = pc[11] | p[2];
        ea[10:6] = pc[10:6] | {b[3:2], c, p[1:0]};
        ea[5:0]  = {a, b[1:0]};
        check(rom_re == 1'b1 && done == 1'b0, "R4 fetch cycle", {rom_re, done}, 2'b10);
        check(rom_addr[5:0] == ea[5:0], "R1 offset field", rom_addr[5:0], ea[5:0]);
        check(rom_addr[10:6] == ea[10:6], "R2 page merge", rom_addr[10:6], ea[10:6]);
        check(rom_addr[11] == ea[11], "R3 bank bit", rom_addr[11], ea[11]);
        @(negedge clk);
        check(rom_re == 1'b0 && done == 1'b1, "R4 done cycle", {rom_re, done}, 2'b01);
        @(negedge clk);
        start = 1'b0; ab_we = 1'b0;
        w = rom_fn(ea);
        eacc = w[8] ? w[7:4] : a;
        eb   = w[8] ? w[3:0] : b;
        if (w[9]) begin
            exp_r2 = w[7:4];
            exp_r3 = w[3:0];
        end
        check(rom_re == 1'b0 && done == 1'b0, "R8 no restart while busy", {rom_re, done}, 2'b00);
        if (w[9:8] == 2'b00)
            check({acc_out, b_out, r2_out, r3_out} == {eacc, eb, exp_r2, exp_r3},
                  "R7 no write", {acc_out, b_out, r2_out, r3_out}, {eacc, eb, exp_r2, exp_r3});
        check({acc_out, b_out} == {eacc, eb}, w[8] ? "R5 acc/B load" : "R8 acc/B untouched",
              {acc_out, b_out}, {eacc, eb});
        check({r2_out, r3_out} == {exp_r2, exp_r3}, w[9] ? "R6 R2/R3 load" : "R6 R2/R3 hold",
              {r2_out, r3_out}, {exp_r2, exp_r3});
    endtask

    initial begin
        logic [11:0] pcs [3];
        pcs[0] = 12'h000; pcs[1] = 12'h8A5; pcs[2] = 12'h240;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check({acc_out, b_out, r2_out, r3_out} == 16'h0, "R9 regs cleared",
              {acc_out, b_out, r2_out, r3_out}, 0);
        check(rom_re == 1'b0 && done == 1'b0, "R9 idle outputs", {rom_re, done}, 0);
        for (int k = 0; k < 3; k++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    for (int c = 0; c < 2; c++)
                        for (int p = 0; p < 8; p++)
                            run_one(pcs[k], 4'(a), 4'(b), 1'(c), 3'(p));
        finish_up();
    end
endmodule